// File: doc/BRIEF.md
# Power Mode and Clock Controller

This block is the system-control unit of a small microcontroller. Software sets the operating mode through two 8-bit control registers on a simple synchronous register bus. The block then drives the enables of the fast and slow oscillators, picks which of them clocks the system, and gates the CPU/watchdog clock, the general peripheral clock and the time-base timer clock. It covers the run modes (NORMAL1/2 on the fast clock, SLOW1/2 on the slow clock), the halt modes (IDLE0/1/2 and SLEEP0/1/2) and a full STOP.

STOP ends when the wake pin goes active, either on its rising edge or while it is high. Before the CPU clock comes back, a warm-up count runs on the clock of the mode being returned to. An interrupt-release input ends the halt modes at once. Illegal oscillator settings raise a reset request. A write that asks for both halt kinds together is dropped and recorded in a sticky error flag. The fast and slow clocks are not modelled as clocks. They reach the block as one-cycle tick inputs in the single clock domain.

Top module: `pmc_mode_ctrl`

## Requirements
- R1: After reset, control register 0 reads 0x00, control register 1 reads 0x80, and `mode` is NORMAL1 (code 0) with the CPU, peripheral and timer clocks enabled.
- R2: Register 0 (`reg_sel`=0) holds stop in bit 7, wake-level select in bit 6, return-to-slow in bit 5, output-hold in bit 4 and the warm-up select in bits 3:2. Register 1 (`reg_sel`=1) holds fast-osc on in bit 7, slow-osc on in bit 6, slow-clock select in bit 5, cpu-halt in bit 4 and timer-only halt in bit 2. Unlisted bits read 0, and writes are accepted only while the CPU clock runs.
- R3: Register 1 bit 5 switches `sysclk_sel` and the run mode at once: NORMAL1 (0) or NORMAL2 (1) when it is 0 and slow-osc is off or on; SLOW1 (2) or SLOW2 (3) when it is 1 and fast-osc is off or on.
- R4: Writing register 0 with bit 7 set enters STOP (code 10) on the next cycle, with all clock gates and both oscillator enables low.
- R5: `port_hiz` is high only in STOP, and only when output-hold (register 0 bit 4) is 0.
- R6: With wake-level select 0, STOP ends only on a rising edge of `wake_pin`, and always returns to NORMAL whatever the return-to-slow bit holds. A pin that is already high does not end it.
- R7: With wake-level select 1, STOP ends in any cycle where `wake_pin` is high. It returns to SLOW when return-to-slow is 1 and to NORMAL otherwise.
- R8: After STOP ends, `mode` is WARM (code 11) with the CPU clock off and only the target oscillator enabled. It stays there for N ticks of that oscillator's tick input. For NORMAL, N is 3·2^A, 2^A, 3·2^B or 2^C for warm-up select 0..3. For SLOW, N is 3·2^D, 2^D, 3·2^E or 2^E. A..E are the exponent parameters, with defaults 16, 14, 10, 13 and 6.
- R9: Writing cpu-halt=1 gives IDLE1/IDLE2 (5/6) from NORMAL1/2 or SLEEP1/SLEEP2 (8/9) from SLOW1/2, with the CPU clock off and the peripheral clock on.
- R10: Writing timer-only-halt=1 gives IDLE0 (4) or SLEEP0 (7), with the CPU and peripheral clocks off and the timer clock on.
- R11: `irq_release` in any halt mode returns to the prior run mode on the next cycle and clears both halt bits.
- R12: A register 1 write with bits 4 and 2 both set changes nothing: mode and register contents stay as they were. It also sets `cfg_err`, which stays set until reset.
- R13: `rst_req` is high when both oscillators are off, when fast-osc is off on the fast clock, or when slow-osc is off on the slow clock.
- R14: Leaving STOP clears register 0 bit 7. Returning from warm-up sets fast-osc and clears slow-clock select (NORMAL), or sets slow-osc and slow-clock select (SLOW).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | Register select for read and write |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data of the selected register |
| wake_pin | input | 1 | STOP wake input |
| irq_release | input | 1 | Interrupt that ends a halt mode |
| hf_tick | input | 1 | One pulse per fast-oscillator cycle |
| lf_tick | input | 1 | One pulse per slow-oscillator cycle |
| hf_osc_en | output | 1 | Fast oscillator enable |
| lf_osc_en | output | 1 | Slow oscillator enable |
| sysclk_sel | output | 1 | 1 = slow clock drives the system |
| cpu_clk_en | output | 1 | CPU and watchdog clock gate |
| periph_clk_en | output | 1 | General peripheral clock gate |
| tbt_clk_en | output | 1 | Time-base timer clock gate |
| port_hiz | output | 1 | Put port outputs in high impedance |
| rst_req | output | 1 | Reset request for illegal oscillator setup |
| cfg_err | output | 1 | Sticky illegal halt-write flag |
| mode | output | 4 | Current operating mode code |

## Verification
Each halt kind is entered from both the fast and the slow run mode, and each is left by interrupt. This separates the IDLE codes from the SLEEP codes and the CPU-only gating from the timer-only gating. STOP is entered with the wake pin already high and later pulsed, which tells edge release apart from level release. A set return-to-slow bit under edge release shows that it is ignored there. Level release is run toward both NORMAL and SLOW with different warm-up selects, and the slow tick runs at half rate so that counting on the wrong oscillator would show. Separate writes that clear each oscillator-enable combination tell the three reset-request cases apart.

// File: rtl/pmc_pkg.sv
// Shared types for the power mode controller.
// Assumes a single clock domain; oscillator activity arrives as ticks.
package pmc_pkg;

    // Internal controller states
    typedef enum logic [2:0] {
        ST_RUN      = 3'd0,
        ST_HALT_CPU = 3'd1,
        ST_HALT_TG  = 3'd2,
        ST_STOP     = 3'd3,
        ST_WARM     = 3'd4
    } pmc_state_e;

    // Externally visible mode codes
    typedef enum logic [3:0] {
        MODE_NORMAL1 = 4'd0,
        MODE_NORMAL2 = 4'd1,
        MODE_SLOW1   = 4'd2,
        MODE_SLOW2   = 4'd3,
        MODE_IDLE0   = 4'd4,
        MODE_IDLE1   = 4'd5,
        MODE_IDLE2   = 4'd6,
        MODE_SLEEP0  = 4'd7,
        MODE_SLEEP1  = 4'd8,
        MODE_SLEEP2  = 4'd9,
        MODE_STOP    = 4'd10,
        MODE_WARM    = 4'd11
    } pmc_mode_e;

    // Register 0 contents, packed in bit order 7..2
    typedef struct packed {
        logic       stop;
        logic       lvl_wake;
        logic       ret_slow;
        logic       out_hold;
        logic [1:0] wut;
    } ctl0_t;

    // Register 1 contents, packed as bits 7,6,5,4,2
    typedef struct packed {
        logic fast_on;
        logic slow_on;
        logic slow_sel;
        logic cpu_halt;
        logic tg_halt;
    } ctl1_t;

endpackage

// File: rtl/pmc_regs.sv
// Control register pair with write decoding and self-clearing bits.
// Writes are honoured only while the CPU runs (run_ok); clear and
// return events come from the mode FSM and never coincide with writes.
module pmc_regs
    import pmc_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic        sel,
    input  logic [7:0]  wr_data,
    input  logic        run_ok,
    input  logic        clr_stop,
    input  logic        clr_halt,
    input  logic        ret_normal,
    input  logic        ret_slow,
    output ctl0_t       c0,
    output ctl1_t       c1,
    output logic        err_sticky,
    output logic [7:0]  rd_data,
    output logic        go_stop,
    output logic        go_cpu_halt,
    output logic        go_tg_halt
);

    logic wr0, wr1, bad1;
    logic unused_low;

    // Decode write strobes and the illegal double-halt request
    always_comb begin
        wr0         = wr_en && run_ok && !sel;
        wr1         = wr_en && run_ok && sel;
        bad1        = wr1 && wr_data[4] && wr_data[2];
        go_stop     = wr0 && wr_data[7];
        go_cpu_halt = wr1 && !bad1 && wr_data[4];
        go_tg_halt  = wr1 && !bad1 && wr_data[2];
    end

    assign unused_low = ^wr_data[1:0];

    // Register storage, self-clears and return updates
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            c0         <= '0;
            c1         <= '{fast_on: 1'b1, default: 1'b0};
            err_sticky <= 1'b0;
        end else begin
            if (wr0)
                c0 <= ctl0_t'(wr_data[7:2]);
            if (wr1 && !bad1)
                c1 <= ctl1_t'({wr_data[7:4], wr_data[2]});
            if (bad1)
                err_sticky <= 1'b1;
            if (clr_stop)
                c0.stop <= 1'b0;
            if (clr_halt) begin
                c1.cpu_halt <= 1'b0;
                c1.tg_halt  <= 1'b0;
            end
            if (ret_normal) begin
                c1.fast_on  <= 1'b1;
                c1.slow_sel <= 1'b0;
            end
            if (ret_slow) begin
                c1.slow_on  <= 1'b1;
                c1.slow_sel <= 1'b1;
            end
        end
    end

    // Read mux; undefined bits return 0
    always_comb begin
        if (sel)
            rd_data = {c1.fast_on, c1.slow_on, c1.slow_sel, c1.cpu_halt,
                       1'b0, c1.tg_halt, 2'b00};
        else
            rd_data = {c0, 2'b00};
    end

endmodule

// File: rtl/pmc_warmup.sv
// Warm-up down-counter for STOP release. Loads the selected length on
// load and counts ticks of the target oscillator; expire pulses on the
// tick that ends the final count.
module pmc_warmup #(
    parameter int CNT_W     = 20,
    parameter int HF_EXP_A  = 16,
    parameter int HF_EXP_B  = 14,
    parameter int HF_EXP_C  = 10,
    parameter int LF_EXP_D  = 13,
    parameter int LF_EXP_E  = 6
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       load,
    input  logic       to_slow,
    input  logic [1:0] wut,
    input  logic       hf_tick,
    input  logic       lf_tick,
    output logic       target_slow,
    output logic       expire
);

    localparam logic [CNT_W-1:0] HF_LEN0 = CNT_W'(3 << HF_EXP_A);
    localparam logic [CNT_W-1:0] HF_LEN1 = CNT_W'(1 << HF_EXP_A);
    localparam logic [CNT_W-1:0] HF_LEN2 = CNT_W'(3 << HF_EXP_B);
    localparam logic [CNT_W-1:0] HF_LEN3 = CNT_W'(1 << HF_EXP_C);
    localparam logic [CNT_W-1:0] LF_LEN0 = CNT_W'(3 << LF_EXP_D);
    localparam logic [CNT_W-1:0] LF_LEN1 = CNT_W'(1 << LF_EXP_D);
    localparam logic [CNT_W-1:0] LF_LEN2 = CNT_W'(3 << LF_EXP_E);
    localparam logic [CNT_W-1:0] LF_LEN3 = CNT_W'(1 << LF_EXP_E);
    localparam logic [CNT_W-1:0] ONE     = CNT_W'(1);

    logic [CNT_W-1:0] cnt, load_val;
    logic             tick;

    // Pick the warm-up length for the target clock
    always_comb begin
        case ({to_slow, wut})
            3'b000:  load_val = HF_LEN0;
            3'b001:  load_val = HF_LEN1;
            3'b010:  load_val = HF_LEN2;
            3'b011:  load_val = HF_LEN3;
            3'b100:  load_val = LF_LEN0;
            3'b101:  load_val = LF_LEN1;
            3'b110:  load_val = LF_LEN2;
            default: load_val = LF_LEN3;
        endcase
    end

    assign tick   = target_slow ? lf_tick : hf_tick;
    assign expire = tick && (cnt == ONE);

    // Counter and target latch
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt         <= '0;
            target_slow <= 1'b0;
        end else if (load) begin
            cnt         <= load_val;
            target_slow <= to_slow;
        end else if (tick && cnt != '0) begin
            cnt <= cnt - ONE;
        end
    end

endmodule

// File: rtl/pmc_fsm.sv
// Operating-mode state machine. Takes decoded write events, the wake
// pin, the interrupt release and the warm-up expiry; issues the
// register self-clear and return events.
module pmc_fsm
    import pmc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       go_stop,
    input  logic       go_cpu_halt,
    input  logic       go_tg_halt,
    input  logic       lvl_wake,
    input  logic       ret_slow_sel,
    input  logic       wake_pin,
    input  logic       irq_release,
    input  logic       expire,
    input  logic       target_slow,
    output pmc_state_e state,
    output logic       start_warm,
    output logic       warm_to_slow,
    output logic       clr_stop,
    output logic       clr_halt,
    output logic       ret_normal,
    output logic       ret_slow
);

    pmc_state_e nxt;
    logic       wake_q, edge_rel, lvl_rel;

    assign edge_rel = !lvl_wake && wake_pin && !wake_q;
    assign lvl_rel  = lvl_wake && wake_pin;

    // Next-state and event decode
    always_comb begin
        nxt          = state;
        start_warm   = 1'b0;
        warm_to_slow = 1'b0;
        clr_stop     = 1'b0;
        clr_halt     = 1'b0;
        ret_normal   = 1'b0;
        ret_slow     = 1'b0;
        case (state)
            ST_RUN: begin
                if (go_stop)          nxt = ST_STOP;
                else if (go_cpu_halt) nxt = ST_HALT_CPU;
                else if (go_tg_halt)  nxt = ST_HALT_TG;
            end
            ST_HALT_CPU, ST_HALT_TG: begin
                if (irq_release) begin
                    nxt      = ST_RUN;
                    clr_halt = 1'b1;
                end
            end
            ST_STOP: begin
                if (edge_rel || lvl_rel) begin
                    nxt          = ST_WARM;
                    start_warm   = 1'b1;
                    warm_to_slow = lvl_rel && ret_slow_sel;
                    clr_stop     = 1'b1;
                end
            end
            ST_WARM: begin
                if (expire) begin
                    nxt        = ST_RUN;
                    ret_normal = !target_slow;
                    ret_slow   = target_slow;
                end
            end
            default: nxt = ST_RUN;
        endcase
    end

    // State and wake-pin history registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ST_RUN;
            wake_q <= 1'b0;
        end else begin
            state  <= nxt;
            wake_q <= wake_pin;
        end
    end

endmodule

// File: rtl/pmc_mode_ctrl.sv
// Top of the power mode and clock controller. Joins registers, FSM and
// warm-up counter, and derives mode code, clock gates, oscillator
// enables, port high-Z and reset request from state and registers.
module pmc_mode_ctrl
    import pmc_pkg::*;
#(
    parameter int CNT_W    = 20,
    parameter int HF_EXP_A = 16,
    parameter int HF_EXP_B = 14,
    parameter int HF_EXP_C = 10,
    parameter int LF_EXP_D = 13,
    parameter int LF_EXP_E = 6
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       reg_wr,
    input  logic       reg_sel,
    input  logic [7:0] reg_wdata,
    output logic [7:0] reg_rdata,
    input  logic       wake_pin,
    input  logic       irq_release,
    input  logic       hf_tick,
    input  logic       lf_tick,
    output logic       hf_osc_en,
    output logic       lf_osc_en,
    output logic       sysclk_sel,
    output logic       cpu_clk_en,
    output logic       periph_clk_en,
    output logic       tbt_clk_en,
    output logic       port_hiz,
    output logic       rst_req,
    output logic       cfg_err,
    output logic [3:0] mode
);

    ctl0_t      c0;
    ctl1_t      c1;
    pmc_state_e state;
    pmc_mode_e  mode_e;
    logic go_stop, go_cpu_halt, go_tg_halt;
    logic start_warm, warm_to_slow, clr_stop, clr_halt, ret_normal, ret_slow;
    logic expire, target_slow;
    logic unused_top;

    assign unused_top = ^{c0.stop, c1.cpu_halt, c1.tg_halt};

    pmc_regs u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(reg_wr), .sel(reg_sel),
        .wr_data(reg_wdata), .run_ok(state == ST_RUN),
        .clr_stop(clr_stop), .clr_halt(clr_halt),
        .ret_normal(ret_normal), .ret_slow(ret_slow),
        .c0(c0), .c1(c1), .err_sticky(cfg_err), .rd_data(reg_rdata),
        .go_stop(go_stop), .go_cpu_halt(go_cpu_halt), .go_tg_halt(go_tg_halt)
    );

    pmc_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .go_stop(go_stop),
        .go_cpu_halt(go_cpu_halt), .go_tg_halt(go_tg_halt),
        .lvl_wake(c0.lvl_wake), .ret_slow_sel(c0.ret_slow),
        .wake_pin(wake_pin), .irq_release(irq_release),
        .expire(expire), .target_slow(target_slow), .state(state),
        .start_warm(start_warm), .warm_to_slow(warm_to_slow),
        .clr_stop(clr_stop), .clr_halt(clr_halt),
        .ret_normal(ret_normal), .ret_slow(ret_slow)
    );

    pmc_warmup #(
        .CNT_W(CNT_W), .HF_EXP_A(HF_EXP_A), .HF_EXP_B(HF_EXP_B),
        .HF_EXP_C(HF_EXP_C), .LF_EXP_D(LF_EXP_D), .LF_EXP_E(LF_EXP_E)
    ) u_warm (
        .clk(clk), .rst_n(rst_n), .load(start_warm), .to_slow(warm_to_slow),
        .wut(c0.wut), .hf_tick(hf_tick), .lf_tick(lf_tick),
        .target_slow(target_slow), .expire(expire)
    );

    // Mode code from state and clock/oscillator settings
    always_comb begin
        case (state)
            ST_RUN:      mode_e = c1.slow_sel ? (c1.fast_on ? MODE_SLOW2 : MODE_SLOW1)
                                              : (c1.slow_on ? MODE_NORMAL2 : MODE_NORMAL1);
            ST_HALT_CPU: mode_e = c1.slow_sel ? (c1.fast_on ? MODE_SLEEP2 : MODE_SLEEP1)
                                              : (c1.slow_on ? MODE_IDLE2 : MODE_IDLE1);
            ST_HALT_TG:  mode_e = c1.slow_sel ? MODE_SLEEP0 : MODE_IDLE0;
            ST_STOP:     mode_e = MODE_STOP;
            default:     mode_e = MODE_WARM;
        endcase
    end

    assign mode = mode_e;

    // Clock gates, oscillator enables, port control, reset request
    always_comb begin
        cpu_clk_en    = (state == ST_RUN);
        periph_clk_en = (state == ST_RUN) || (state == ST_HALT_CPU);
        tbt_clk_en    = (state != ST_STOP) && (state != ST_WARM);
        case (state)
            ST_STOP: begin
                hf_osc_en = 1'b0;
                lf_osc_en = 1'b0;
            end
            ST_WARM: begin
                hf_osc_en = !target_slow;
                lf_osc_en = target_slow;
            end
            default: begin
                hf_osc_en = c1.fast_on;
                lf_osc_en = c1.slow_on;
            end
        endcase
        sysclk_sel = c1.slow_sel;
        port_hiz   = (state == ST_STOP) && !c0.out_hold;
        rst_req    = (!c1.fast_on && !c1.slow_on) ||
                     (!c1.fast_on && !c1.slow_sel) ||
                     (!c1.slow_on && c1.slow_sel);
    end

endmodule

// File: rtl/pmc_checker.sv
// Temporal checks on the controller's ports, bound to the top module.
module pmc_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       reg_wr,
    input logic       reg_sel,
    input logic [7:0] reg_wdata,
    input logic       irq_release,
    input logic       cpu_clk_en,
    input logic       periph_clk_en,
    input logic       tbt_clk_en,
    input logic       hf_osc_en,
    input logic       lf_osc_en,
    input logic       port_hiz,
    input logic       cfg_err,
    input logic [3:0] mode
);

    p_stop_gates_r4: assert property (@(posedge clk) disable iff (!rst_n)
        mode == 4'd10 |-> !cpu_clk_en && !periph_clk_en && !tbt_clk_en && !hf_osc_en && !lf_osc_en);

    p_hiz_in_stop_r5: assert property (@(posedge clk) disable iff (!rst_n)
        port_hiz |-> mode == 4'd10);

    p_stop_exit_warm_r8: assert property (@(posedge clk) disable iff (!rst_n)
        mode == 4'd10 |=> mode == 4'd10 || mode == 4'd11);

    p_warm_one_osc_r8: assert property (@(posedge clk) disable iff (!rst_n)
        mode == 4'd11 |-> !cpu_clk_en && (hf_osc_en ^ lf_osc_en));

    p_cpu_halt_gates_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 4'd5 || mode == 4'd6 || mode == 4'd8 || mode == 4'd9) |-> !cpu_clk_en && periph_clk_en);

    p_tg_halt_gates_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 4'd4 || mode == 4'd7) |-> !cpu_clk_en && !periph_clk_en && tbt_clk_en);

    p_irq_wake_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (mode >= 4'd4 && mode <= 4'd9 && irq_release) |=> cpu_clk_en);

    p_bad_write_err_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_sel && reg_wdata[4] && reg_wdata[2] && cpu_clk_en) |=> cfg_err && $stable(mode));

    p_err_sticky_r12: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err |=> cfg_err);

endmodule

bind pmc_mode_ctrl pmc_checker u_chk (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .irq_release(irq_release),
    .cpu_clk_en(cpu_clk_en), .periph_clk_en(periph_clk_en),
    .tbt_clk_en(tbt_clk_en), .hf_osc_en(hf_osc_en), .lf_osc_en(lf_osc_en),
    .port_hiz(port_hiz), .cfg_err(cfg_err), .mode(mode)
);

// File: tb/tb_pmc_mode_ctrl.sv
// Bench: behavioural reference model stepped with the stimulus and
// compared against every output once per clock.
module tb_pmc_mode_ctrl;

    localparam int EA = 4, EB = 3, EC = 2, ED = 3, EE = 1;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_wr = 1'b0, reg_sel = 1'b0;
    logic [7:0] reg_wdata = 8'h00;
    logic       wake_pin = 1'b0, irq_release = 1'b0;
    logic       hf_tick = 1'b1, lf_tick = 1'b0;
    logic [7:0] reg_rdata;
    logic       hf_osc_en, lf_osc_en, sysclk_sel, cpu_clk_en, periph_clk_en;
    logic       tbt_clk_en, port_hiz, rst_req, cfg_err;
    logic [3:0] mode;

    int    checks = 0, errors = 0;
    bit    finished = 1'b0;
    string cur_req = "R1";
    bit    w_lvl = 1'b0, rd_sel = 1'b0, lf_ph = 1'b0;

    // reference model state
    int       m_st;
    bit [7:0] m_r0, m_r1;
    bit       m_err, m_tslow, m_wprev;
    int       m_cnt;

    pmc_mode_ctrl #(.CNT_W(20), .HF_EXP_A(EA), .HF_EXP_B(EB), .HF_EXP_C(EC),
                    .LF_EXP_D(ED), .LF_EXP_E(EE)) dut (.*);

    always #5 clk = ~clk;

    function automatic int warm_len(bit slow, bit [1:0] w);
        if (!slow) return (w == 0) ? 3 * (1 << EA) : (w == 1) ? (1 << EA) :
                          (w == 2) ? 3 * (1 << EB) : (1 << EC);
        return (w == 0) ? 3 * (1 << ED) : (w == 1) ? (1 << ED) :
               (w == 2) ? 3 * (1 << EE) : (1 << EE);
    endfunction

    task automatic model_reset();
        m_st = 0; m_r0 = 8'h00; m_r1 = 8'h80; m_err = 0;
        m_tslow = 0; m_wprev = 0; m_cnt = 0;
    endtask

    task automatic model_step(bit wr, bit sel, bit [7:0] wd, bit wk, bit irq, bit lft);
        bit w0, w1, bad, tick;
        w0  = wr && m_st == 0 && !sel;
        w1  = wr && m_st == 0 && sel;
        bad = w1 && wd[4] && wd[2];
        case (m_st)
            0: if (w0 && wd[7]) m_st = 3;
               else if (w1 && !bad && wd[4]) m_st = 1;
               else if (w1 && !bad && wd[2]) m_st = 2;
            1, 2: if (irq) begin m_st = 0; m_r1[4] = 0; m_r1[2] = 0; end
            3: if ((!m_r0[6] && wk && !m_wprev) || (m_r0[6] && wk)) begin
                   m_tslow = m_r0[6] && m_r0[5];
                   m_cnt = warm_len(m_tslow, m_r0[3:2]);
                   m_r0[7] = 0;
                   m_st = 4;
               end
            default: begin
                tick = m_tslow ? lft : 1'b1;
                if (tick) begin
                    if (m_cnt == 1) begin
                        m_st = 0;
                        if (m_tslow) begin m_r1[6] = 1; m_r1[5] = 1; end
                        else begin m_r1[7] = 1; m_r1[5] = 0; end
                    end
                    m_cnt--;
                end
            end
        endcase
        if (w0) m_r0 = wd & 8'hFC;
        if (w1 && !bad) m_r1 = wd & 8'hF4;
        if (bad) m_err = 1;
        m_wprev = wk;
    endtask

    task automatic check(string name, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", cur_req, name, act, exp);
        end
    endtask

    task automatic compare_all();
        int em; bit sl, fo, so;
        sl = m_r1[5]; fo = m_r1[7]; so = m_r1[6];
        case (m_st)
            0: em = sl ? (fo ? 3 : 2) : (so ? 1 : 0);
            1: em = sl ? (fo ? 9 : 8) : (so ? 6 : 5);
            2: em = sl ? 7 : 4;
            3: em = 10;
            default: em = 11;
        endcase
        check("mode", int'(mode), em);
        check("cpu_clk_en", int'(cpu_clk_en), int'(m_st == 0));
        check("periph_clk_en", int'(periph_clk_en), int'(m_st <= 1));
        check("tbt_clk_en", int'(tbt_clk_en), int'(m_st <= 2));
        check("hf_osc_en", int'(hf_osc_en), (m_st == 3) ? 0 : (m_st == 4) ? int'(!m_tslow) : int'(fo));
        check("lf_osc_en", int'(lf_osc_en), (m_st == 3) ? 0 : (m_st == 4) ? int'(m_tslow) : int'(so));
        check("sysclk_sel", int'(sysclk_sel), int'(sl));
        check("port_hiz", int'(port_hiz), int'(m_st == 3 && !m_r0[4]));
        check("rst_req", int'(rst_req), int'((!fo && !so) || (!fo && !sl) || (!so && sl)));
        check("cfg_err", int'(cfg_err), int'(m_err));
        check("reg_rdata", int'(reg_rdata), rd_sel ? int'(m_r1) : int'(m_r0));
    endtask

    // One clock: drive at negedge, step model, compare at next negedge
    task automatic cyc(bit wr, bit sel, bit [7:0] wd, bit irq);
        reg_wr = wr; reg_sel = wr ? sel : rd_sel; reg_wdata = wd;
        wake_pin = w_lvl; irq_release = irq; lf_tick = lf_ph; hf_tick = 1'b1;
        if (!wr) rd_sel = rd_sel; else rd_sel = sel;
        model_step(wr, sel, wd, w_lvl, irq, lf_ph);
        lf_ph = !lf_ph;
        @(negedge clk);
        compare_all();
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) cyc(1'b0, rd_sel, 8'h00, 1'b0);
    endtask

    task automatic wr(bit sel, bit [7:0] d);
        cyc(1'b1, sel, d, 1'b0);
    endtask

    task automatic do_reset();
        rst_n = 1'b0; reg_wr = 1'b0; irq_release = 1'b0; w_lvl = 1'b0; wake_pin = 1'b0;
        repeat (2) @(negedge clk);
        model_reset();
        rst_n = 1'b1;
        compare_all();
    endtask

    initial begin
        @(negedge clk);
        cur_req = "R1"; do_reset(); rd_sel = 0; idle(1); rd_sel = 1; idle(1);
        cur_req = "R2"; wr(0, 8'h5F); idle(1); wr(0, 8'h00); rd_sel = 1; idle(1);
        cur_req = "R3"; wr(1, 8'hC0); wr(1, 8'hE0); wr(1, 8'h60); wr(1, 8'hE0);
        wr(1, 8'hC0); wr(1, 8'h80);
        cur_req = "R9"; wr(1, 8'h90); idle(3);
        cur_req = "R11"; cyc(0, 1, 8'h00, 1); idle(1);
        cur_req = "R9"; wr(1, 8'hE0); wr(1, 8'hF0); idle(2);
        cur_req = "R11"; cyc(0, 1, 8'h00, 1); idle(1);
        cur_req = "R10"; wr(1, 8'hE4); idle(2); cyc(0, 1, 8'h00, 1);
        wr(1, 8'hC0); wr(1, 8'h84); idle(2); cyc(0, 1, 8'h00, 1); wr(1, 8'h80);
        cur_req = "R12"; wr(1, 8'h94); idle(2); wr(1, 8'h80); idle(1);
        // edge release with pin already high, return bit set
        cur_req = "R6"; w_lvl = 1; idle(2); wr(0, 8'hAC); idle(5);
        w_lvl = 0; idle(1); w_lvl = 1;
        cur_req = "R8"; idle(6);
        cur_req = "R14"; rd_sel = 0; idle(1); w_lvl = 0; idle(1);
        // level release toward SLOW and NORMAL
        cur_req = "R5"; wr(1, 8'hE0); wr(0, 8'hF4); idle(3);
        cur_req = "R7"; w_lvl = 1; idle(1); w_lvl = 0;
        cur_req = "R8"; idle(20);
        cur_req = "R14"; rd_sel = 1; idle(1); wr(1, 8'hC0);
        cur_req = "R7"; wr(0, 8'hD0); idle(2); w_lvl = 1; idle(1); w_lvl = 0;
        cur_req = "R8"; idle(52);
        cur_req = "R4"; wr(0, 8'hC8); idle(2); w_lvl = 1; idle(1); w_lvl = 0; idle(28);
        cur_req = "R13"; wr(1, 8'h00); idle(1); do_reset();
        wr(1, 8'h40); idle(1); do_reset();
        wr(1, 8'hE0); wr(1, 8'hA0); idle(1); do_reset();
        idle(2);
        if (!finished) begin
            finished = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++; errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule